// File: doc/BRIEF.md
# Transmit Descriptor Slot Controller

This block owns a small ring of transmit descriptor slots. Each slot pairs a buffer-address register with a status/command register. Host software fills a slot by writing the buffer address and then writing the status register with a frame length. That status write hands the slot to the hardware, and the same word carries an early-transmit threshold in 32-byte units. The controller visits the slots in a fixed ring order. For each queued slot it reads the frame bytes from memory, one per request, through a simple read port with one cycle of latency. The bytes leave on a byte stream with valid/ready handshaking and an end-of-frame marker.

Frames shorter than the minimum frame size are padded with zero bytes on the stream. When a frame has been sent, the slot goes back to the host with a success flag. The slot's bit is set in a summary register that shows all slots at once, and a transmit-done interrupt-status bit is raised. Software clears that bit by writing a one to it.

Top module: `txslot_ctrl`

## Requirements
- R1: After reset every slot status register reads 0x0000_2000 (only the host-owns bit 13 set), the summary register (offset 0x40) and the interrupt-status register (offset 0x44) read zero, and no byte is presented on the stream.
- R2: A write to the status register of slot n (offset 0x10 + 4n) while the host owns the slot does five things: it stores the frame length from bits [12:0], stores the threshold from bits [21:16], clears host-owns (bit 13), clears done-OK (bit 15) and clears summary bit n.
- R3: The address register of slot n (offset 0x20 + 4n) reads back what was written. Writes to either register of a slot whose host-owns bit is clear are ignored.
- R4: Slots are served strictly in ring order 0, 1, 2, 3, 0. A slot queued out of turn waits until every earlier slot in the ring has been queued and sent. Only one slot is ever active.
- R5: Byte i of a frame is read from address base + i, in increasing order. The read data is taken in the cycle after the read request.
- R6: A frame whose length is below 60 is sent as 60 bytes, the bytes past the length being zero. A frame of 60 bytes or more is sent at its own length. The end-of-frame marker is high on the final byte only.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last stay unchanged.
- R8: When a frame has been sent, the slot reads host-owns (bit 13) and done-OK (bit 15) set, with its length and threshold intact and bits 14, 29, 30 and 31 zero. Summary bit n is set, and interrupt-status bit 2 is set.
- R9: Writing a one to bit 2 of the interrupt-status register clears it. A completion in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 8 | Memory byte, valid the cycle after the request |
| tx_ready | input | 1 | Stream consumer accepts a byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The bench aims at the pad boundary with frames of 0, 1, 59, 60 and 61 bytes. A design off by one there would send 59 or 61 bytes, or would put memory data where zeros belong. It queues a slot ahead of the ring pointer and expects the stream to stay silent until the skipped slot is filled. An engine that picked any queued slot would send the frames out of order. It also writes a second time into a slot that is already queued and expects the first length and address to survive; a design that accepted the write would send the wrong frame. Back-pressure on every other cycle exposes a stream that drops or changes a byte while stalled, and the interrupt bit is cleared and read back to catch a clear that has no effect.

// File: rtl/txslot_pkg.sv
package txslot_pkg;

   // status word bit positions decoded by host software
   localparam int ST_OWN_BIT   = 13;
   localparam int ST_UNDR_BIT  = 14;
   localparam int ST_OK_BIT    = 15;
   localparam int ST_THR_LSB   = 16;
   localparam int IRQ_TXOK_BIT = 2;

   typedef enum logic [2:0] {
      F_IDLE,
      F_REQ,
      F_WAIT,
      F_SEND,
      F_DONE
   } fetch_state_t;

endpackage

// File: rtl/txslot_regs.sv
module txslot_regs #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 13,
   parameter int THR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic              addr_we,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [THR_W-1:0]  thr_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              done,
   output logic              own,
   output logic              ok,
   output logic              sum_bit,
   output logic [LEN_W-1:0]  len,
   output logic [THR_W-1:0]  thr,
   output logic [ADDR_W-1:0] base
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own     <= 1'b1;
         ok      <= 1'b0;
         sum_bit <= 1'b0;
         len     <= '0;
         thr     <= '0;
         base    <= '0;
      end else if (done) begin
         own     <= 1'b1;
         ok      <= 1'b1;
         sum_bit <= 1'b1;
      end else begin
         if (stat_we && own) begin
            len     <= len_in;
            thr     <= thr_in;
            own     <= 1'b0;
            ok      <= 1'b0;
            sum_bit <= 1'b0;
         end
         if (addr_we && own) begin
            base <= base_in;
         end
      end
   end

   AST_LOCKED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!own && stat_we) |=> $stable(len) && $stable(thr)); // R3
   AST_LOCKED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!own && addr_we) |=> $stable(base)); // R3
   AST_DONE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !own); // R8
   AST_SUM_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      sum_bit |-> (own && ok)); // R8

endmodule

// File: rtl/txslot_sched.sv
module txslot_sched #(
   parameter int NUM_SLOTS = 4,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [SLOT_W-1:0] ptr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (advance) begin
         ptr <= ptr + 1'b1;
      end
   end

   AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) |-> (ptr == SLOT_W'($past(ptr) + 1'b1))); // R4

endmodule

// File: rtl/txslot_fetch.sv
module txslot_fetch #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 13,
   parameter int MIN_FRAME = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_base,
   input  logic [LEN_W-1:0]  start_len,
   output logic              idle,
   output logic              done,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last
);
   import txslot_pkg::*;

   localparam logic [LEN_W-1:0] MINF = LEN_W'(MIN_FRAME);

   fetch_state_t      st;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  total_q;
   logic [LEN_W-1:0]  cnt;
   logic [7:0]        byte_q;
   logic              in_body;
   logic              at_end;

   assign in_body = (cnt < len_q);
   assign at_end  = (cnt == total_q - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         base_q  <= '0;
         len_q   <= '0;
         total_q <= '0;
         cnt     <= '0;
         byte_q  <= '0;
      end else begin
         case (st)
            F_IDLE: begin
               if (start) begin
                  base_q  <= start_base;
                  len_q   <= start_len;
                  total_q <= (start_len < MINF) ? MINF : start_len;
                  cnt     <= '0;
                  st      <= F_REQ;
               end
            end
            F_REQ: begin
               if (in_body) begin
                  st <= F_WAIT;
               end else begin
                  byte_q <= 8'h00;
                  st     <= F_SEND;
               end
            end
            F_WAIT: begin
               byte_q <= mem_rd_data;
               st     <= F_SEND;
            end
            F_SEND: begin
               if (tx_ready) begin
                  if (at_end) begin
                     st <= F_DONE;
                  end else begin
                     cnt <= cnt + 1'b1;
                     st  <= F_REQ;
                  end
               end
            end
            F_DONE:  st <= F_IDLE;
            default: st <= F_IDLE;
         endcase
      end
   end

   always_comb begin
      idle        = (st == F_IDLE);
      done        = (st == F_DONE);
      mem_rd_en   = (st == F_REQ) && in_body;
      mem_rd_addr = base_q + ADDR_W'(cnt);
      tx_valid    = (st == F_SEND);
      tx_data     = byte_q;
      tx_last     = (st == F_SEND) && at_end;
   end

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R7
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !in_body) |-> (tx_data == 8'h00)); // R6
   AST_NO_READ_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !mem_rd_en); // R5

endmodule

// File: rtl/txslot_ctrl.sv
module txslot_ctrl #(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 13,
   parameter int THR_W     = 6,
   parameter int MIN_FRAME = 60,
   parameter int REG_AW    = 8,
   parameter int STAT_BASE = 'h10,
   parameter int ADDR_BASE = 'h20,
   parameter int SUM_OFF   = 'h40,
   parameter int IRQ_OFF   = 'h44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last
);
   import txslot_pkg::*;

   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   // elaboration-time parameter checks
   if ((1 << SLOT_W) != NUM_SLOTS || NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two of at least 2");
   end
   if (LEN_W > ST_OWN_BIT) begin : g_bad_len
      $error("LEN_W must fit below the host-owns bit");
   end
   if (THR_W > 13) begin : g_bad_thr
      $error("THR_W must end below bit 29");
   end
   if (ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must not exceed the register width");
   end
   if (MIN_FRAME < 1 || MIN_FRAME >= (1 << LEN_W)) begin : g_bad_min
      $error("MIN_FRAME out of range for LEN_W");
   end
   if (STAT_BASE + 4 * NUM_SLOTS > ADDR_BASE) begin : g_bad_map
      $error("status window overlaps address window");
   end

   logic [NUM_SLOTS-1:0] own_v;
   logic [NUM_SLOTS-1:0] ok_v;
   logic [NUM_SLOTS-1:0] sum_v;
   logic [NUM_SLOTS-1:0] done_v;
   logic [NUM_SLOTS-1:0] stat_we_v;
   logic [NUM_SLOTS-1:0] addr_we_v;
   logic [LEN_W-1:0]     len_a  [NUM_SLOTS];
   logic [THR_W-1:0]     thr_a  [NUM_SLOTS];
   logic [ADDR_W-1:0]    base_a [NUM_SLOTS];
   logic [31:0]          stat_word [NUM_SLOTS];

   logic [SLOT_W-1:0] ptr;
   logic              f_idle;
   logic              f_done;
   logic              f_start;
   logic              irq_txok;
   logic              irq_clr;

   for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
      assign stat_we_v[n] = reg_wr && (reg_addr == REG_AW'(STAT_BASE + 4 * n));
      assign addr_we_v[n] = reg_wr && (reg_addr == REG_AW'(ADDR_BASE + 4 * n));
      assign done_v[n]    = f_done && (ptr == SLOT_W'(n));

      txslot_regs #(
         .ADDR_W (ADDR_W),
         .LEN_W  (LEN_W),
         .THR_W  (THR_W)
      ) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .stat_we (stat_we_v[n]),
         .addr_we (addr_we_v[n]),
         .len_in  (reg_wdata[LEN_W-1:0]),
         .thr_in  (reg_wdata[ST_THR_LSB +: THR_W]),
         .base_in (reg_wdata[ADDR_W-1:0]),
         .done    (done_v[n]),
         .own     (own_v[n]),
         .ok      (ok_v[n]),
         .sum_bit (sum_v[n]),
         .len     (len_a[n]),
         .thr     (thr_a[n]),
         .base    (base_a[n])
      );

      always_comb begin
         stat_word[n]                        = '0;
         stat_word[n][LEN_W-1:0]             = len_a[n];
         stat_word[n][ST_OWN_BIT]            = own_v[n];
         stat_word[n][ST_OK_BIT]             = ok_v[n];
         stat_word[n][ST_THR_LSB +: THR_W]   = thr_a[n];
      end
   end

   txslot_sched #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (f_done),
      .ptr     (ptr)
   );

   assign f_start = f_idle && !own_v[ptr];

   txslot_fetch #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .MIN_FRAME (MIN_FRAME)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (f_start),
      .start_base  (base_a[ptr]),
      .start_len   (len_a[ptr]),
      .idle        (f_idle),
      .done        (f_done),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .mem_rd_data (mem_rd_data),
      .tx_ready    (tx_ready),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .tx_last     (tx_last)
   );

   assign irq_clr = reg_wr && (reg_addr == REG_AW'(IRQ_OFF)) && reg_wdata[IRQ_TXOK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_txok <= 1'b0;
      end else if (f_done) begin
         irq_txok <= 1'b1;
      end else if (irq_clr) begin
         irq_txok <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (reg_addr == REG_AW'(STAT_BASE + 4 * i)) reg_rdata = stat_word[i];
         if (reg_addr == REG_AW'(ADDR_BASE + 4 * i)) reg_rdata = 32'(base_a[i]);
      end
      if (reg_addr == REG_AW'(SUM_OFF)) reg_rdata = 32'(sum_v);
      if (reg_addr == REG_AW'(IRQ_OFF)) reg_rdata[IRQ_TXOK_BIT] = irq_txok;
   end

   AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_v)); // R4
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      f_done |=> irq_txok); // R9
   AST_SEND_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !own_v[ptr]); // R4

endmodule

// File: tb/txslot_ctrl_tb.sv
module txslot_ctrl_tb_top;

   localparam int NV = 7;
   localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2340, 32'h0000_0F00,
                                           32'h0001_0080, 32'h0000_5555, 32'h0000_3000,
                                           32'h0000_7000};
   localparam int V_LEN  [NV] = '{64, 1, 60, 100, 0, 61, 59};
   localparam int V_THR  [NV] = '{8, 0, 63, 1, 5, 2, 3};
   localparam int V_MODE [NV] = '{0, 1, 0, 1, 0, 1, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [7:0]  mem_rd_data = '0;
   logic        tx_ready = 1'b1;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_last;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] got [0:255];
   int  got_n;
   int  last_cnt;
   int  hold_err;

   always #10 clk = ~clk;

   txslot_ctrl dut_i (
      .clk (clk), .rst_n (rst_n),
      .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data),
      .tx_ready (tx_ready), .tx_valid (tx_valid), .tx_data (tx_data), .tx_last (tx_last)
   );

   function automatic logic [7:0] mem_fn(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // memory model: one cycle of read latency
   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem_fn(mem_rd_addr);
   end

   task automatic check(input bit cond, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // gathers one frame; mode 1 stalls every other cycle
   task automatic collect(input int mode);
      bit   fin = 1'b0;
      bit   stalled = 1'b0;
      logic [7:0] pdata = '0;
      logic plast = 1'b0;
      int   cyc = 0;
      got_n = 0;
      last_cnt = 0;
      hold_err = 0;
      while (!fin && cyc < 5000) begin
         @(negedge clk);
         if (stalled && (!tx_valid || tx_data != pdata || tx_last != plast)) hold_err++;
         tx_ready = (mode == 1) ? cyc[0] : 1'b1;
         if (tx_valid && tx_ready) begin
            if (got_n < 256) got[got_n] = tx_data;
            got_n++;
            if (tx_last) begin
               last_cnt++;
               fin = 1'b1;
            end
         end
         stalled = tx_valid && !tx_ready;
         pdata   = tx_data;
         plast   = tx_last;
         cyc++;
      end
      @(negedge clk);
      tx_ready = 1'b1;
   endtask

   task automatic check_frame(input logic [31:0] base, input int len, input string tag);
      int exp_n = (len < 60) ? 60 : len;
      int bad = 0;
      logic [7:0] e;
      check(got_n == exp_n, {tag, " R6 frame byte count"}, got_n, exp_n);
      check(last_cnt == 1, {tag, " R6 end marker on final byte only"}, last_cnt, 1);
      for (int i = 0; i < exp_n && i < 256 && i < got_n; i++) begin
         e = (i < len) ? mem_fn(base + i) : 8'h00;
         if (got[i] != e) begin
            if (bad == 0)
               check(1'b0, {tag, " R5 byte content"}, got[i], e);
            bad++;
         end
      end
      if (bad == 0) check(1'b1, "R5", 0, 0);
   endtask

   initial begin
      logic [31:0] rd;
      int slot;
      logic [31:0] sw;
      bit   seen;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int n = 0; n < 4; n++) begin
         reg_read(8'(8'h10 + 4 * n), rd);
         check(rd == 32'h0000_2000, "R1 slot status after reset", rd, 32'h0000_2000);
      end
      reg_read(8'h40, rd);
      check(rd == 0, "R1 summary after reset", rd, 0);
      reg_read(8'h44, rd);
      check(rd == 0, "R1 interrupt status after reset", rd, 0);
      check(!tx_valid && !mem_rd_en, "R1 stream idle after reset", {30'b0, tx_valid, mem_rd_en}, 0);

      // vector table walk: slots used in ring order
      for (int v = 0; v < NV; v++) begin
         slot = v % 4;
         sw = (32'(V_THR[v]) << 16) | 32'(V_LEN[v]);
         reg_write(8'(8'h20 + 4 * slot), V_BASE[v]);
         reg_read(8'(8'h20 + 4 * slot), rd);
         check(rd == V_BASE[v], "R3 address readback", rd, V_BASE[v]);
         reg_write(8'(8'h10 + 4 * slot), sw);
         reg_read(8'h40, rd);
         check(rd[slot] == 1'b0, "R2 summary bit cleared by status write", rd, 0);
         collect(V_MODE[v]);
         check_frame(V_BASE[v], V_LEN[v], "table");
         if (V_MODE[v] == 1)
            check(hold_err == 0, "R7 stream held under back-pressure", hold_err, 0);
         repeat (2) @(negedge clk);
         reg_read(8'(8'h10 + 4 * slot), rd);
         check(rd == (sw | 32'h0000_A000), "R8 slot status after completion", rd,
               sw | 32'h0000_A000);
         reg_read(8'h40, rd);
         check(rd[slot] == 1'b1, "R8 summary bit set", rd, 32'(1) << slot);
         reg_read(8'h44, rd);
         check(rd == 32'h4, "R8 interrupt status set", rd, 32'h4);
         reg_write(8'h44, 32'h4);
         reg_read(8'h44, rd);
         check(rd == 0, "R9 interrupt status cleared", rd, 0);
      end

      // ring pointer now at slot 3; queue slot 0 out of turn (R4)
      reg_write(8'h20, 32'h0000_0300);
      reg_write(8'h10, 32'h0000_0003);
      seen = 1'b0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (tx_valid || mem_rd_en) seen = 1'b1;
      end
      check(!seen, "R4 out-of-turn slot must wait", seen, 0);

      // writes into a queued slot are ignored (R3)
      reg_write(8'h10, 32'h0000_0046);
      reg_write(8'h20, 32'h0000_0999);
      reg_read(8'h10, rd);
      check(rd == 32'h0000_0003, "R3 status write to queued slot ignored", rd, 32'h3);
      reg_read(8'h20, rd);
      check(rd == 32'h0000_0300, "R3 address write to queued slot ignored", rd, 32'h300);
      reg_read(8'h40, rd);
      check(rd[0] == 1'b0, "R2 summary bit of requeued slot clear", rd, 0);

      // fill slot 3; expect slot 3 first, then slot 0
      reg_write(8'h2C, 32'h0000_0200);
      reg_write(8'h1C, 32'h0000_0002);
      collect(0);
      check_frame(32'h0000_0200, 2, "R4 first served slot 3");
      collect(1);
      check_frame(32'h0000_0300, 3, "R4 then slot 0");
      check(hold_err == 0, "R7 hold on padded frame", hold_err, 0);
      repeat (2) @(negedge clk);
      reg_read(8'h10, rd);
      check(rd == 32'h0000_A003, "R8 slot 0 status after completion", rd, 32'h0000_A003);
      reg_read(8'h40, rd);
      check(rd[3:0] == 4'hF, "R8 summary shows all slots done", rd, 32'hF);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule